// File: doc/BRIEF.md
# DRAM Request Scheduler with Row Policy

This block keeps up to eight pending memory requests (read or write, each carrying bank, row, column and a tag) and decides every cycle which single DRAM command, if any, to send next. It reads the open or closed state and the open row of every bank from an external bank tracker. For each queued request it works out the command that request needs next. A request whose row is already open needs only its column command. A request whose bank holds another row needs a precharge. A request whose bank is closed needs an activate.

Requests are served out of order. Ready read row hits go first, then ready write row hits, and only then the oldest request in the queue. A request that has waited too long overrides all of this. A policy input selects open-page or close-page operation. In close-page mode a column command carries an auto-precharge flag, unless another queued request targets the same bank and row. Timing legality comes in from outside as one allow input per command kind. Completion of each request is reported with its tag in the cycle its column command issues.

Top module: `dram_req_sched`

## Requirements
- R1: After reset the queue is empty, `cmd_valid` and `done_valid` are low and `req_ready` is high.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low exactly while 8 requests are held.
- R3: A request whose bank is open on its own row needs a column command: `cmd_type` 2 for a read, 3 for a write, with that request's bank and column.
- R4: A request whose bank is open on another row needs a precharge (`cmd_type` 0) to that bank. A request whose bank is closed needs an activate (`cmd_type` 1) with its bank and row.
- R5: Without an overdue request, the oldest read whose column command is allowed is chosen first. If there is none, the oldest write whose column command is allowed is chosen.
- R6: If no such row hit exists, the oldest queued request issues the command it needs, or nothing is issued if that command is not allowed.
- R7: At most one command per cycle. A command of a kind is issued only while its allow input (`allow_pre`, `allow_act`, `allow_rd`, `allow_wr`) is high.
- R8: A request counts one age step per rising clock edge spent queued (0 when accepted). Once the oldest request's age exceeds 64, only that request may issue.
- R9: With `close_page` low, `cmd_autopre` is always low.
- R10: With `close_page` high, a column command has `cmd_autopre` high unless another queued request has the same bank and row.
- R11: When a column command issues, `done_valid` is high in that cycle with the request's tag, and the request leaves the queue. The other requests keep their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_tag | input | TAG_W | Identifier returned on completion |
| req_ready | output | 1 | Queue can accept a request |
| close_page | input | 1 | 1 = close-page policy, 0 = open-page |
| bank_open | input | 2**BANK_W | Per-bank open flag from the bank tracker |
| bank_row | input | 2**BANK_W*ROW_W | Per-bank open row, bank b at bits b*ROW_W |
| allow_pre | input | 1 | Precharge legal this cycle |
| allow_act | input | 1 | Activate legal this cycle |
| allow_rd | input | 1 | Read legal this cycle |
| allow_wr | input | 1 | Write legal this cycle |
| cmd_valid | output | 1 | A command issues this cycle |
| cmd_type | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |
| cmd_autopre | output | 1 | Column command closes the row afterwards |
| done_valid | output | 1 | A request completes this cycle |
| done_tag | output | TAG_W | Tag of the completing request |

## Verification
Commands and completions appear in the same cycle they are chosen, so an error in the queue contents, the stored order or an age counter shows at the command port in the first cycle where that entry matters. A lost or shifted entry produces a wrong bank, row, column or tag on the next selection that reaches it. A corrupted order moves a hit or an oldest-request choice to a different request. A stuck age counter shows up only after 64 cycles, so the bench holds precharges back for long stretches to make overdue requests appear. The bench's bank tracker reacts to every issued command, so a wrong auto-precharge flag changes the next command needed for that bank.

// File: rtl/dram_req_sched.sv
module dram_req_sched #(
  parameter int DEPTH     = 8,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int TAG_W     = 4,
  parameter int AGE_LIMIT = 64,
  localparam int BANKS    = 1 << BANK_W,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int AGE_W    = $clog2(AGE_LIMIT + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [BANK_W-1:0]      req_bank,
  input  logic [ROW_W-1:0]       req_row,
  input  logic [COL_W-1:0]       req_col,
  input  logic [TAG_W-1:0]       req_tag,
  output logic                   req_ready,
  input  logic                   close_page,
  input  logic [BANKS-1:0]       bank_open,
  input  logic [BANKS*ROW_W-1:0] bank_row,
  input  logic                   allow_pre,
  input  logic                   allow_act,
  input  logic                   allow_rd,
  input  logic                   allow_wr,
  output logic                   cmd_valid,
  output logic [1:0]             cmd_type,
  output logic [BANK_W-1:0]      cmd_bank,
  output logic [ROW_W-1:0]       cmd_row,
  output logic [COL_W-1:0]       cmd_col,
  output logic                   cmd_autopre,
  output logic                   done_valid,
  output logic [TAG_W-1:0]       done_tag
);

  localparam logic [1:0] C_PRE = 2'd0, C_ACT = 2'd1, C_RD = 2'd2, C_WR = 2'd3;

  logic              q_v   [DEPTH];
  logic              q_w   [DEPTH];
  logic [BANK_W-1:0] q_bank[DEPTH];
  logic [ROW_W-1:0]  q_row [DEPTH];
  logic [COL_W-1:0]  q_col [DEPTH];
  logic [TAG_W-1:0]  q_tag [DEPTH];
  logic [AGE_W-1:0]  q_age [DEPTH];
  logic [CNT_W-1:0]  cnt;

  logic              n_v   [DEPTH];
  logic              n_w   [DEPTH];
  logic [BANK_W-1:0] n_bank[DEPTH];
  logic [ROW_W-1:0]  n_row [DEPTH];
  logic [COL_W-1:0]  n_col [DEPTH];
  logic [TAG_W-1:0]  n_tag [DEPTH];
  logic [AGE_W-1:0]  n_age [DEPTH];

  logic [1:0]        need  [DEPTH];
  logic [DEPTH-1:0]  hit, rdy;
  logic [3:0]        allow_vec;
  logic              rdh_f, wrh_f, urgent, go, pop, push, shared;
  logic [IDX_W-1:0]  rdh_i, wrh_i, sel;
  logic [CNT_W-1:0]  pos;

  assign allow_vec = {allow_wr, allow_rd, allow_act, allow_pre};
  assign req_ready = cnt < CNT_W'(DEPTH);
  assign push      = req_valid && req_ready;
  assign urgent    = q_v[0] && (q_age[0] > AGE_W'(AGE_LIMIT));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit[i]  = q_v[i] && bank_open[q_bank[i]] &&
                (bank_row[q_bank[i]*ROW_W +: ROW_W] == q_row[i]);
      need[i] = hit[i] ? (q_w[i] ? C_WR : C_RD)
                       : (bank_open[q_bank[i]] ? C_PRE : C_ACT);
      rdy[i]  = q_v[i] && allow_vec[need[i]];
    end
  end

  always_comb begin
    rdh_f = 1'b0; rdh_i = '0;
    wrh_f = 1'b0; wrh_i = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i] && rdy[i] && !q_w[i]) begin rdh_f = 1'b1; rdh_i = IDX_W'(i); end
      if (hit[i] && rdy[i] &&  q_w[i]) begin wrh_f = 1'b1; wrh_i = IDX_W'(i); end
    end
    go = 1'b0; sel = '0;
    if (urgent)     go = rdy[0];
    else if (rdh_f) begin go = 1'b1; sel = rdh_i; end
    else if (wrh_f) begin go = 1'b1; sel = wrh_i; end
    else            go = rdy[0];
  end

  always_comb begin
    shared = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (q_v[j] && IDX_W'(j) != sel && q_bank[j] == q_bank[sel] && q_row[j] == q_row[sel])
        shared = 1'b1;
  end

  assign cmd_valid   = go;
  assign cmd_type    = need[sel];
  assign cmd_bank    = q_bank[sel];
  assign cmd_row     = q_row[sel];
  assign cmd_col     = q_col[sel];
  assign pop         = go && need[sel][1];
  assign cmd_autopre = pop && close_page && !shared;
  assign done_valid  = pop;
  assign done_tag    = q_tag[sel];
  assign pos         = cnt - CNT_W'(pop);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      n_v[i] = 1'b0; n_w[i] = 1'b0; n_bank[i] = '0; n_row[i] = '0;
      n_col[i] = '0; n_tag[i] = '0; n_age[i] = '0;
      if (pop && i >= int'(sel)) begin
        if (i < DEPTH - 1) begin
          n_v[i] = q_v[i+1]; n_w[i] = q_w[i+1]; n_bank[i] = q_bank[i+1];
          n_row[i] = q_row[i+1]; n_col[i] = q_col[i+1]; n_tag[i] = q_tag[i+1];
          n_age[i] = q_age[i+1];
        end
      end else begin
        n_v[i] = q_v[i]; n_w[i] = q_w[i]; n_bank[i] = q_bank[i];
        n_row[i] = q_row[i]; n_col[i] = q_col[i]; n_tag[i] = q_tag[i];
        n_age[i] = q_age[i];
      end
      if (n_v[i] && n_age[i] <= AGE_W'(AGE_LIMIT)) n_age[i] = n_age[i] + 1'b1;
    end
    if (push) begin
      n_v[pos[IDX_W-1:0]]    = 1'b1;
      n_w[pos[IDX_W-1:0]]    = req_write;
      n_bank[pos[IDX_W-1:0]] = req_bank;
      n_row[pos[IDX_W-1:0]]  = req_row;
      n_col[pos[IDX_W-1:0]]  = req_col;
      n_tag[pos[IDX_W-1:0]]  = req_tag;
      n_age[pos[IDX_W-1:0]]  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_v[i] <= 1'b0; q_w[i] <= 1'b0; q_bank[i] <= '0; q_row[i] <= '0;
        q_col[i] <= '0; q_tag[i] <= '0; q_age[i] <= '0;
      end
    end else begin
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      for (int i = 0; i < DEPTH; i++) begin
        q_v[i] <= n_v[i]; q_w[i] <= n_w[i]; q_bank[i] <= n_bank[i];
        q_row[i] <= n_row[i]; q_col[i] <= n_col[i]; q_tag[i] <= n_tag[i];
        q_age[i] <= n_age[i];
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  assert_cmd_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> allow_vec[cmd_type]);
  assert_col_on_open_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type[1]) |->
      (bank_open[cmd_bank] && bank_row[cmd_bank*ROW_W +: ROW_W] == cmd_row));
  assert_act_closed_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == C_ACT) |-> !bank_open[cmd_bank]);
  assert_open_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !close_page |-> !cmd_autopre);
  assert_done_col_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (cmd_valid && cmd_type[1]));
  assert_pop_frees_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !req_valid) |=> req_ready);

endmodule

// File: tb/dram_req_sched_tb.sv
module dram_req_sched_tb;
  localparam int DEPTH = 8, BANK_W = 3, ROW_W = 14, COL_W = 10, TAG_W = 4, LIM = 64;
  localparam int BANKS = 1 << BANK_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, close_page = 0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic allow_pre = 0, allow_act = 0, allow_rd = 0, allow_wr = 0;
  logic [BANKS-1:0]       bank_open;
  logic [BANKS*ROW_W-1:0] bank_row;
  logic req_ready, cmd_valid, cmd_autopre, done_valid;
  logic [1:0] cmd_type;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [TAG_W-1:0] done_tag;

  always #5 clk = ~clk;

  dram_req_sched u_dut (.*);

  logic t_open [BANKS];
  logic [ROW_W-1:0] t_row [BANKS];
  always_comb
    for (int b = 0; b < BANKS; b++) begin
      bank_open[b] = t_open[b];
      bank_row[b*ROW_W +: ROW_W] = t_row[b];
    end

  int m_n;
  logic m_w [DEPTH];
  logic [BANK_W-1:0] m_b [DEPTH];
  logic [ROW_W-1:0] m_r [DEPTH];
  logic [COL_W-1:0] m_c [DEPTH];
  logic [TAG_W-1:0] m_t [DEPTH];
  int m_age [DEPTH];

  int checks = 0, errors = 0;
  logic e_v, e_ap; logic [1:0] e_ty; int e_sel; string e_why;

  function automatic logic [1:0] need_of(int i);
    if (t_open[m_b[i]] && t_row[m_b[i]] == m_r[i]) return m_w[i] ? 2'd3 : 2'd2;
    return t_open[m_b[i]] ? 2'd0 : 2'd1;
  endfunction

  function automatic logic ok_of(logic [1:0] c);
    case (c) 2'd0: return allow_pre; 2'd1: return allow_act;
      2'd2: return allow_rd; default: return allow_wr; endcase
  endfunction

  task automatic predict();
    int rh = -1, wh = -1;
    e_v = 0; e_sel = 0; e_ap = 0; e_why = "R6 oldest";
    for (int i = m_n - 1; i >= 0; i--) begin
      if (need_of(i) == 2'd2 && allow_rd) rh = i;
      if (need_of(i) == 2'd3 && allow_wr) wh = i;
    end
    if (m_n > 0 && m_age[0] > LIM) begin e_why = "R8 overdue"; e_v = ok_of(need_of(0)); end
    else if (rh >= 0) begin e_v = 1; e_sel = rh; e_why = "R5 read hit"; end
    else if (wh >= 0) begin e_v = 1; e_sel = wh; e_why = "R5 write hit"; end
    else if (m_n > 0) e_v = ok_of(need_of(0));
    if (e_v) begin
      e_ty = need_of(e_sel);
      if (e_ty[1]) begin
        e_ap = close_page;
        for (int j = 0; j < m_n; j++)
          if (j != e_sel && m_b[j] == m_b[e_sel] && m_r[j] == m_r[e_sel]) e_ap = 0;
        e_why = {e_why, e_ty[1] ? " R3 R11" : "", close_page ? " R10" : " R9"};
      end else e_why = {e_why, " R4"};
    end else begin e_ty = 0; e_why = {e_why, " R7 idle"}; end
  endtask

  task automatic check_cycle();
    logic bad;
    predict();
    bad = (cmd_valid !== e_v) || (req_ready !== (m_n < DEPTH));
    if (e_v) bad = bad || cmd_type !== e_ty || cmd_bank !== m_b[e_sel] ||
       (e_ty == 1 && cmd_row !== m_r[e_sel]) ||
       (e_ty[1] && (cmd_col !== m_c[e_sel] || done_valid !== 1'b1 || done_tag !== m_t[e_sel])) ||
       (!e_ty[1] && done_valid !== 1'b0) || cmd_autopre !== e_ap;
    else bad = bad || done_valid !== 1'b0;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s R2: got v=%0d ty=%0d b=%0d r=%0d c=%0d ap=%0d dn=%0d tag=%0d rdy=%0d exp v=%0d ty=%0d b=%0d r=%0d c=%0d ap=%0d tag=%0d rdy=%0d",
        e_why, cmd_valid, cmd_type, cmd_bank, cmd_row, cmd_col, cmd_autopre, done_valid, done_tag,
        req_ready, e_v, e_ty, m_b[e_sel], m_r[e_sel], m_c[e_sel], e_ap, m_t[e_sel], m_n < DEPTH);
    end
  endtask

  task automatic step(int p_req, int p_allow, logic no_pre);
    logic do_pop, do_push;
    int pos;
    req_valid = ($urandom_range(99) < p_req);
    req_write = ($urandom_range(2) == 0);
    req_bank  = BANK_W'($urandom_range(3));
    req_row   = ROW_W'($urandom_range(2));
    req_col   = COL_W'($urandom);
    req_tag   = TAG_W'($urandom);
    allow_pre = !no_pre && ($urandom_range(99) < p_allow);
    allow_act = ($urandom_range(99) < p_allow);
    allow_rd  = ($urandom_range(99) < p_allow);
    allow_wr  = ($urandom_range(99) < p_allow);
    #1;
    check_cycle();
    do_pop  = e_v && e_ty[1];
    do_push = req_valid && m_n < DEPTH;
    @(posedge clk); #1;
    if (e_v) begin
      if (e_ty == 0) t_open[m_b[e_sel]] = 0;
      else if (e_ty == 1) begin t_open[m_b[e_sel]] = 1; t_row[m_b[e_sel]] = m_r[e_sel]; end
      else if (e_ap) t_open[m_b[e_sel]] = 0;
    end
    if (do_pop) begin
      for (int i = e_sel; i < DEPTH - 1; i++) begin
        m_w[i] = m_w[i+1]; m_b[i] = m_b[i+1]; m_r[i] = m_r[i+1];
        m_c[i] = m_c[i+1]; m_t[i] = m_t[i+1]; m_age[i] = m_age[i+1];
      end
      m_n--;
    end
    for (int i = 0; i < m_n; i++) if (m_age[i] <= LIM) m_age[i]++;
    if (do_push) begin
      pos = m_n;
      m_w[pos] = req_write; m_b[pos] = req_bank; m_r[pos] = req_row;
      m_c[pos] = req_col; m_t[pos] = req_tag; m_age[pos] = 0; m_n++;
    end
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog R1: got hung run, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_n = 0;
    for (int b = 0; b < BANKS; b++) begin t_open[b] = 0; t_row[b] = '0; end
    for (int i = 0; i < DEPTH; i++) begin
      m_w[i] = 0; m_b[i] = '0; m_r[i] = '0; m_c[i] = '0; m_t[i] = '0; m_age[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (cmd_valid !== 0 || done_valid !== 0 || req_ready !== 1) begin
      errors++;
      $display("FAIL R1 reset: got v=%0d dn=%0d rdy=%0d exp 0 0 1", cmd_valid, done_valid, req_ready);
    end
    rst_n = 1;
    @(negedge clk);
    repeat (30)   step(90, 0, 0);
    repeat (200)  step(40, 100, 0);
    repeat (1500) step(50, 70, 0);
    close_page = 1;
    repeat (1500) step(50, 70, 0);
    repeat (300)  step(60, 80, 1);
    close_page = 0;
    repeat (300)  step(60, 80, 1);
    repeat (20)   step(90, 0, 0);
    repeat (100)  step(0, 100, 0);
    checks++;
    if (req_ready !== 1 || cmd_valid !== 0 || m_n != 0) begin
      errors++;
      $display("FAIL R2 drain: got rdy=%0d v=%0d n=%0d exp 1 0 0", req_ready, cmd_valid, m_n);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule